// File: doc/BRIEF.md
# Washing Machine Sequencing Controller

This block is the central sequencer of a domestic washing machine. It sits idle until the user presses start. It then takes the target temperature from the panel and locks the door. After that it steps through fill, heat, main wash, drain, refill, rinse and a final spin with drain. At the end it lights the completion indicator and releases the door. Every actuator is a plain level output. The controller uses no feedback from an actuator apart from the door lock sensor.

Some phases wait on a sensor: the fill, the heat-up, and the point at which the drum becomes empty. The others count pulses of a one-minute tick input. The bench can run that tick much faster than once a minute, which keeps a full cycle short in simulation. If the door sensor reports unlocked during an active phase, every actuator goes off. The block then holds a fault indication until reset.

Top module: `wash_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and after reset is released, every actuator output is 0 and led_o is 3'b000. The LED bits are: bit 0 = cycle busy, bit 1 = cycle complete, bit 2 = fault.
- R2: In idle, all outputs stay off until start_i is sampled high. At that edge the controller captures set_temp_i and asserts door_lock_o and busy. No other actuator turns on until door_locked_i is high.
- R3: Once the door is confirmed locked, inlet_o is high and stays high until drum_full_i is sampled high.
- R4: After the fill, heater_o is high until temp_i is at least the setpoint captured at start. Changes on set_temp_i after start have no effect.
- R5: The main wash drives motor_o to agitate. It lasts until WASH_MIN pulses of min_tick_i have been counted, starting from entry into the phase.
- R6: The drain then drives pump_o. It ends after drum_full_i is low and DRAIN_EXTRA further tick pulses have been counted. Ticks only count while drum_full_i is low.
- R7: inlet_o then refills the drum until drum_full_i is high. A rinse follows, with motor_o on agitate, for RINSE_MIN tick pulses.
- R8: The final phase drives pump_o together with motor_o on spin. It ends after the drum is empty and SPIN_EXTRA further ticks have passed. The block then shows complete (led_o = 3'b010), with every actuator off and the door unlocked. A new start_i begins a new cycle.
- R9: motor_o uses 2'b00 for off, 2'b01 for agitate and 2'b10 for spin. 2'b11 never appears.
- R10: If door_locked_i is low in any phase from fill through final spin, all actuators go off and led_o becomes 3'b100. This holds, ignoring start_i, until reset.
- R11: inlet_o and pump_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request from the panel |
| set_temp_i | input | TEMP_W | Target temperature selected on the panel |
| temp_i | input | TEMP_W | Measured water temperature |
| drum_full_i | input | 1 | Water level sensor, high when the drum is full |
| door_locked_i | input | 1 | Door lock sensor, high when locked |
| min_tick_i | input | 1 | One-cycle pulse per minute of phase time |
| led_o | output | 3 | Indicator panel: busy, complete, fault |
| inlet_o | output | 1 | Inlet valve open |
| motor_o | output | 2 | Agitator motor command |
| heater_o | output | 1 | Heater on |
| door_lock_o | output | 1 | Door lock actuator |
| pump_o | output | 1 | Drain pump on |

## Verification
In the first full cycle, the door confirmation arrives late and the drum stays full for some ticks after each drain starts. This separates ticks counted from phase entry from ticks counted only once the drum is empty. The panel setpoint is raised after start to a value above the final measured temperature, so heating stops only if the captured setpoint is used. A second cycle is launched from the complete state with the water already hot, which gives a heat phase one cycle long. The door is then dropped during the wash, and a start pulse is applied while faulted, to show that the fault holds until reset.

// File: rtl/wash_pkg.sv
package wash_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOCK, ST_FILL, ST_HEAT, ST_WASH, ST_DRAIN,
    ST_REFILL, ST_RINSE, ST_SPIN, ST_DONE, ST_FAULT
  } wash_st_e;

  localparam logic [1:0] MOT_OFF  = 2'b00;
  localparam logic [1:0] MOT_AGI  = 2'b01;
  localparam logic [1:0] MOT_SPIN = 2'b10;

  localparam int LED_W    = 3;
  localparam int LED_BUSY = 0;
  localparam int LED_DONE = 1;
  localparam int LED_ERR  = 2;
endpackage

// File: rtl/wash_phase_timer.sv
module wash_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (en_i && tick_i && !done_o)   cnt_q <= cnt_q + 1'b1;
  end

  // R5: count saturates at the phase limit
  a_r5_cnt_within_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
  a_r5_cnt_holds_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wash_fsm.sv
module wash_fsm
  import wash_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int CNT_W       = 5,
  parameter int WASH_MIN    = 30,
  parameter int RINSE_MIN   = 5,
  parameter int DRAIN_EXTRA = 2,
  parameter int SPIN_EXTRA  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TEMP_W-1:0] set_temp_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              drum_full_i,
  input  logic              door_locked_i,
  input  logic              tmr_done_i,
  output wash_st_e          state_o,
  output logic              tmr_clr_o,
  output logic              tmr_en_o,
  output logic [CNT_W-1:0]  limit_o
);
  wash_st_e          state_q, state_d;
  logic [TEMP_W-1:0] set_q;
  logic              active;
  logic              take_start;

  assign active     = state_q inside {ST_FILL, ST_HEAT, ST_WASH, ST_DRAIN,
                                      ST_REFILL, ST_RINSE, ST_SPIN};
  assign take_start = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_LOCK;
      ST_LOCK:   if (door_locked_i) state_d = ST_FILL;
      ST_FILL:   if (drum_full_i) state_d = ST_HEAT;
      ST_HEAT:   if (temp_i >= set_q) state_d = ST_WASH;
      ST_WASH:   if (tmr_done_i) state_d = ST_DRAIN;
      ST_DRAIN:  if (tmr_done_i && !drum_full_i) state_d = ST_REFILL;
      ST_REFILL: if (drum_full_i) state_d = ST_RINSE;
      ST_RINSE:  if (tmr_done_i) state_d = ST_SPIN;
      ST_SPIN:   if (tmr_done_i && !drum_full_i) state_d = ST_DONE;
      ST_FAULT:  state_d = ST_FAULT;
      default:   state_d = ST_FAULT;
    endcase
    if (active && !door_locked_i) state_d = ST_FAULT;
  end

  always_comb begin
    limit_o  = '0;
    tmr_en_o = 1'b0;
    unique case (state_q)
      ST_WASH:  begin limit_o = CNT_W'(WASH_MIN);    tmr_en_o = 1'b1;         end
      ST_RINSE: begin limit_o = CNT_W'(RINSE_MIN);   tmr_en_o = 1'b1;         end
      ST_DRAIN: begin limit_o = CNT_W'(DRAIN_EXTRA); tmr_en_o = !drum_full_i; end
      ST_SPIN:  begin limit_o = CNT_W'(SPIN_EXTRA);  tmr_en_o = !drum_full_i; end
      default:  ;
    endcase
  end

  assign tmr_clr_o = (state_d != state_q);
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_start) set_q <= set_temp_i;
    end
  end

  a_r2_setpoint_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_start |=> (set_q == $past(set_temp_i)));
  a_r4_setpoint_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HEAT) |=> $stable(set_q));
  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT) |=> (state_q == ST_FAULT));
  a_r2_lock_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK && !door_locked_i) |=> (state_q == ST_LOCK));
endmodule

// File: rtl/wash_out_dec.sv
module wash_out_dec
  import wash_pkg::*;
(
  input  wash_st_e         state_i,
  output logic [LED_W-1:0] led_o,
  output logic             inlet_o,
  output logic [1:0]       motor_o,
  output logic             heater_o,
  output logic             door_lock_o,
  output logic             pump_o
);
  always_comb begin
    led_o       = '0;
    inlet_o     = 1'b0;
    motor_o     = MOT_OFF;
    heater_o    = 1'b0;
    door_lock_o = 1'b0;
    pump_o      = 1'b0;
    unique case (state_i)
      ST_IDLE:  ;
      ST_DONE:  led_o[LED_DONE] = 1'b1;
      ST_FAULT: led_o[LED_ERR]  = 1'b1;
      default: begin
        led_o[LED_BUSY] = 1'b1;
        door_lock_o     = 1'b1;
        unique case (state_i)
          ST_FILL, ST_REFILL: inlet_o  = 1'b1;
          ST_HEAT:            heater_o = 1'b1;
          ST_WASH, ST_RINSE:  motor_o  = MOT_AGI;
          ST_DRAIN:           pump_o   = 1'b1;
          ST_SPIN: begin
            pump_o  = 1'b1;
            motor_o = MOT_SPIN;
          end
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/wash_seq_ctrl.sv
module wash_seq_ctrl
  import wash_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int WASH_MIN    = 30,
  parameter int RINSE_MIN   = 5,
  parameter int DRAIN_EXTRA = 2,
  parameter int SPIN_EXTRA  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TEMP_W-1:0] set_temp_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              drum_full_i,
  input  logic              door_locked_i,
  input  logic              min_tick_i,
  output logic [2:0]        led_o,
  output logic              inlet_o,
  output logic [1:0]        motor_o,
  output logic              heater_o,
  output logic              door_lock_o,
  output logic              pump_o
);
  localparam int MAX_A   = (WASH_MIN > RINSE_MIN) ? WASH_MIN : RINSE_MIN;
  localparam int MAX_B   = (DRAIN_EXTRA > SPIN_EXTRA) ? DRAIN_EXTRA : SPIN_EXTRA;
  localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  wash_st_e         state;
  logic             tmr_clr, tmr_en, tmr_done;
  logic [CNT_W-1:0] limit;

  wash_fsm #(
    .TEMP_W(TEMP_W), .CNT_W(CNT_W), .WASH_MIN(WASH_MIN), .RINSE_MIN(RINSE_MIN),
    .DRAIN_EXTRA(DRAIN_EXTRA), .SPIN_EXTRA(SPIN_EXTRA)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .set_temp_i, .temp_i, .drum_full_i, .door_locked_i,
    .tmr_done_i(tmr_done), .state_o(state), .tmr_clr_o(tmr_clr),
    .tmr_en_o(tmr_en), .limit_o(limit)
  );

  wash_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .en_i(tmr_en), .tick_i(min_tick_i),
    .limit_i(limit), .done_o(tmr_done)
  );

  wash_out_dec u_dec (
    .state_i(state), .led_o, .inlet_o, .motor_o, .heater_o, .door_lock_o, .pump_o
  );

  a_r11_no_fill_while_pump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inlet_o && pump_o));
  a_r9_motor_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    motor_o != 2'b11);
  a_r4_heat_follows_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(heater_o) |-> $past(inlet_o));
  a_r10_fault_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o[LED_ERR] |-> !(inlet_o || heater_o || pump_o || door_lock_o || (motor_o != MOT_OFF)));
endmodule

// File: tb/wash_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module wash_seq_ctrl_tb_top;
  localparam int TW = 8, WM = 30, RM = 5, DE = 2, SE = 3;
  localparam int B_IDLE = 0, B_LOCK = 1, B_FILL = 2, B_HEAT = 3, B_WASH = 4,
                 B_DRAIN = 5, B_REFILL = 6, B_RINSE = 7, B_SPIN = 8,
                 B_DONE = 9, B_FAULT = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, drum_full_i = 1'b0, door_locked_i = 1'b0, min_tick_i = 1'b0;
  logic [TW-1:0] set_temp_i = '0, temp_i = '0;
  logic [2:0] led_o;
  logic inlet_o, heater_o, door_lock_o, pump_o;
  logic [1:0] motor_o;

  int checks = 0, errors = 0, cyc = 0, tick_div = 0;
  bit tick_en = 1'b0;
  int m_st = B_IDLE, m_cnt = 0, m_set = 0;

  always #4 clk_i = ~clk_i;

  wash_seq_ctrl #(.TEMP_W(TW), .WASH_MIN(WM), .RINSE_MIN(RM),
                  .DRAIN_EXTRA(DE), .SPIN_EXTRA(SE)) dut_i (
    .clk_i, .rst_ni, .start_i, .set_temp_i, .temp_i, .drum_full_i, .door_locked_i,
    .min_tick_i, .led_o, .inlet_o, .motor_o, .heater_o, .door_lock_o, .pump_o);

  // reference model of the wash sequence
  always @(posedge clk_i or negedge rst_ni) begin
    int nx, lim;
    bit en, act;
    if (!rst_ni) begin
      m_st = B_IDLE; m_cnt = 0; m_set = 0;
    end else begin
      nx = m_st; lim = 0; en = 0;
      case (m_st)
        B_WASH:  begin lim = WM; en = 1; end
        B_RINSE: begin lim = RM; en = 1; end
        B_DRAIN: begin lim = DE; en = !drum_full_i; end
        B_SPIN:  begin lim = SE; en = !drum_full_i; end
        default: ;
      endcase
      case (m_st)
        B_IDLE, B_DONE: if (start_i) begin nx = B_LOCK; m_set = set_temp_i; end
        B_LOCK:   if (door_locked_i) nx = B_FILL;
        B_FILL:   if (drum_full_i) nx = B_HEAT;
        B_HEAT:   if (int'(temp_i) >= m_set) nx = B_WASH;
        B_WASH:   if (m_cnt == lim) nx = B_DRAIN;
        B_DRAIN:  if (m_cnt == lim && !drum_full_i) nx = B_REFILL;
        B_REFILL: if (drum_full_i) nx = B_RINSE;
        B_RINSE:  if (m_cnt == lim) nx = B_SPIN;
        B_SPIN:   if (m_cnt == lim && !drum_full_i) nx = B_DONE;
        default:  ;
      endcase
      act = (m_st >= B_FILL && m_st <= B_SPIN);
      if (act && !door_locked_i) nx = B_FAULT;
      if (nx != m_st) m_cnt = 0;
      else if (en && min_tick_i && m_cnt < lim) m_cnt++;
      m_st = nx;
    end
  end

  // {led[2:0], inlet, motor[1:0], heater, lock, pump}
  function automatic logic [8:0] exp_out(int s);
    case (s)
      B_IDLE:   return 9'b000_0_00_0_0_0;
      B_LOCK:   return 9'b001_0_00_0_1_0;
      B_FILL, B_REFILL: return 9'b001_1_00_0_1_0;
      B_HEAT:   return 9'b001_0_00_1_1_0;
      B_WASH, B_RINSE: return 9'b001_0_01_0_1_0;
      B_DRAIN:  return 9'b001_0_00_0_1_1;
      B_SPIN:   return 9'b001_0_10_0_1_1;
      B_DONE:   return 9'b010_0_00_0_0_0;
      default:  return 9'b100_0_00_0_0_0;
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      B_IDLE, B_LOCK: return "R2";
      B_FILL: return "R3";
      B_HEAT: return "R4";
      B_WASH: return "R5";
      B_DRAIN: return "R6";
      B_REFILL, B_RINSE: return "R7";
      B_SPIN, B_DONE: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, expv, cyc);
    end
  endtask

  function automatic logic [8:0] outs();
    return {led_o, inlet_o, motor_o, heater_o, door_lock_o, pump_o};
  endfunction

  always @(negedge clk_i) begin
    cyc++;
    if (tick_en) begin
      tick_div++;
      min_tick_i = (tick_div % 3 == 0);
    end else min_tick_i = 1'b0;
    if (rst_ni) begin
      check(req_of(m_st), outs(), exp_out(m_st));
      check("R9", {7'd0, motor_o == 2'b11}, 9'd0);
      check("R11", {7'd0, inlet_o && pump_o}, 9'd0);
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_st(int s);
    while (m_st != s) @(negedge clk_i);
  endtask

  initial begin
    cycles(3);
    check("R1", outs(), 9'd0);           // R1 during reset
    rst_ni = 1'b1;
    cycles(3);
    check("R1", outs(), 9'd0);           // R1 idle after reset
    // first cycle
    set_temp_i = 8'd60; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; set_temp_i = 8'd200;   // R4 late change ignored
    cycles(4);
    check("R2", {door_lock_o, inlet_o, 7'd0}, {2'b10, 7'd0});
    door_locked_i = 1'b1;
    cycles(5);
    check("R3", {inlet_o, 8'd0}, {1'b1, 8'd0});
    drum_full_i = 1'b1; temp_i = 8'd30;
    cycles(6);
    check("R4", {heater_o, 8'd0}, {1'b1, 8'd0});
    temp_i = 8'd100;
    tick_en = 1'b1;
    wait_st(B_WASH); cycles(2);
    check("R5", {motor_o, 7'd0}, {2'b01, 7'd0});
    wait_st(B_DRAIN); cycles(12);
    check("R6", {pump_o, motor_o, 6'd0}, {1'b1, 2'b00, 6'd0});
    drum_full_i = 1'b0;
    wait_st(B_REFILL); cycles(3);
    drum_full_i = 1'b1;
    wait_st(B_RINSE); wait_st(B_SPIN); cycles(1);
    check("R8", {pump_o, motor_o, 6'd0}, {1'b1, 2'b10, 6'd0});
    cycles(5); drum_full_i = 1'b0;
    wait_st(B_DONE); cycles(1);
    check("R8", outs(), 9'b010_0_00_0_0_0);
    // second cycle from complete, water already hot
    drum_full_i = 1'b0; set_temp_i = 8'd10; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    cycles(3); drum_full_i = 1'b1;
    wait_st(B_WASH); cycles(4);
    door_locked_i = 1'b0;
    cycles(2);
    check("R10", outs(), 9'b100_0_00_0_0_0);
    start_i = 1'b1; door_locked_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    cycles(3);
    check("R10", outs(), 9'b100_0_00_0_0_0);
    rst_ni = 1'b0;
    cycles(2);
    check("R1", outs(), 9'd0);
    rst_ni = 1'b1; tick_en = 1'b0;
    cycles(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule